// File: doc/BRIEF.md
# Revertive Clock Reference Selector

This controller chooses which of two reference clocks, a preferred primary and a backup secondary, feeds a downstream PLL. A 2-bit configuration field and a three-level strap pin, presented as a 2-bit level code, together choose between automatic selection and a fixed manual choice. In automatic mode the choice follows two per-input availability flags. Each flag is qualified by a stability counter before it is acted on. The selection falls back to secondary when primary is lost and reverts to primary as soon as primary is qualified again. When neither input is usable the selection parks on secondary and the block raises loss-of-signal and disables the clock outputs.

Every change of the select output comes with a one-cycle request pulse, so that a glitch-free clock multiplexer further down can sequence its handover. An optional one-time handover supports a crystal start-up on the secondary input. When the keep-secondary bit is clear, the secondary path is shut off once automatic mode has settled on primary, and from then on secondary counts as unusable.

The state machine has five states. AUTO_PRI is automatic on primary. AUTO_SEC is automatic on secondary as a backup. AUTO_PARK is automatic with no usable input, parked on secondary; it is also the reset state. MAN_PRI and MAN_SEC are the two manual states. In automatic mode the next state is AUTO_PRI if primary is qualified, otherwise AUTO_SEC if secondary is qualified and its path is enabled, otherwise AUTO_PARK. In manual mode the next state is MAN_SEC or MAN_PRI. Any state can move to any other in one cycle. Each state's select value is registered in the state itself.

Top module: `refclk_selector`

## Requirements
- R1: Reset gives sel_sec=1, los=1, out_dis=1, sec_path_en=1 and switch_req=0.
- R2: With cfg_mode=00 the block is in automatic mode, and pin_lvl has no effect on sel_sec.
- R3: With cfg_mode=01 the pin decides the mode: pin_lvl=00 gives manual primary, 01 gives manual secondary, and 10 or 11 gives automatic mode. sel_sec follows one cycle after the inputs.
- R4: cfg_mode=10 forces sel_sec=0 and cfg_mode=11 forces sel_sec=1 in the following cycle, whatever pin_lvl is.
- R5: A raw availability flag is acted on only after it has held its new value for STABLE_CYC consecutive cycles. A shorter excursion has no effect on any output.
- R6: In automatic mode, once primary is qualified as lost, sel_sec becomes 1 in the next cycle.
- R7: In automatic mode, once primary is qualified as available, sel_sec returns to 0 in the next cycle.
- R8: While neither input is usable, sel_sec stays 1 in automatic mode, and los and out_dis are 1 in the cycle after that condition is qualified. They return to 0 one cycle after either input becomes usable.
- R9: switch_req is 1 for exactly the cycles in which sel_sec differs from its value in the cycle before.
- R10: With keep_sec=0, once the state machine has spent a cycle in automatic primary, sec_path_en goes to 0 and stays there until reset or until keep_sec=1. While it is 0, secondary counts as unavailable.
- R11: With keep_sec=1, sec_path_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Selection mode field |
| pin_lvl | input | 2 | Three-level pin code: 00 low, 01 mid, 10/11 high |
| keep_sec | input | 1 | 1 keeps the secondary path enabled permanently |
| pri_avail | input | 1 | Raw primary availability flag |
| sec_avail | input | 1 | Raw secondary availability flag |
| sel_sec | output | 1 | 1 selects the secondary reference |
| switch_req | output | 1 | One-cycle pulse on every change of sel_sec |
| los | output | 1 | No usable reference |
| out_dis | output | 1 | Clock outputs disabled |
| sec_path_en | output | 1 | Secondary input path enable |

## Verification
The hardest overlap is a qualification commit and a mode or keep-secondary change landing on the same clock edge. One example is primary being qualified back while the mode field leaves automatic. Another is the handover latch setting while keep_sec toggles. Random stimulus with frequent short and long flag excursions, plus occasional mode, pin and keep-secondary changes, produces these collisions many times over. Each cycle is judged against a bench model built from the requirements, which decides which of the two same-cycle causes should win.

// File: rtl/refclk_sel_pkg.sv
package refclk_sel_pkg;

    typedef enum logic [2:0] {
        ST_AUTO_PRI  = 3'd0,
        ST_AUTO_SEC  = 3'd1,
        ST_AUTO_PARK = 3'd2,
        ST_MAN_PRI   = 3'd3,
        ST_MAN_SEC   = 3'd4
    } sel_state_e;

    typedef enum logic [1:0] {
        PIN_LOW  = 2'b00,
        PIN_MID  = 2'b01,
        PIN_HIGH = 2'b10,
        PIN_RSVD = 2'b11
    } pin_lvl_e;

    localparam logic [1:0] MODE_AUTO  = 2'b00;
    localparam logic [1:0] MODE_PIN   = 2'b01;
    localparam logic [1:0] MODE_F_PRI = 2'b10;
    localparam logic [1:0] MODE_F_SEC = 2'b11;

endpackage

// File: rtl/refclk_mode_dec.sv
module refclk_mode_dec
    import refclk_sel_pkg::*;
(
    input  logic [1:0] cfg_mode,
    input  logic [1:0] pin_lvl,
    output logic       auto_en,
    output logic       man_sec
);

    pin_lvl_e pin_e;
    assign pin_e = pin_lvl_e'(pin_lvl);

    always_comb begin
        auto_en = 1'b0;
        man_sec = 1'b0;
        unique case (cfg_mode)
            MODE_AUTO:  auto_en = 1'b1;
            MODE_PIN: begin
                unique case (pin_e)
                    PIN_LOW:  man_sec = 1'b0;
                    PIN_MID:  man_sec = 1'b1;
                    PIN_HIGH: auto_en = 1'b1;
                    PIN_RSVD: auto_en = 1'b1;
                endcase
            end
            MODE_F_PRI: man_sec = 1'b0;
            MODE_F_SEC: man_sec = 1'b1;
        endcase
    end

endmodule

// File: rtl/refclk_qualify.sv
module refclk_qualify #(
    parameter int STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic q_o
);

    localparam int CNT_W = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            q_o   <= 1'b0;
        end else if (raw_i == q_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            q_o   <= raw_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the qualified flag only ever moves to the value the raw flag held
    p_qual_follows_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o != $past(q_o)) |-> ($past(raw_i) == q_o));

endmodule

// File: rtl/refclk_sel_fsm.sv
module refclk_sel_fsm
    import refclk_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic man_sec,
    input  logic pri_ok,
    input  logic sec_ok,
    input  logic keep_sec,
    output logic sel_sec,
    output logic switch_req,
    output logic los,
    output logic sec_path_en
);

    sel_state_e state_q, state_d;
    logic       sel_d_q;
    logic       handed_q;
    logic       los_q;
    logic       sec_use;
    logic       on_auto_pri;

    assign sec_path_en = keep_sec | ~handed_q;
    assign sec_use     = sec_ok & sec_path_en;

    always_comb begin
        if (auto_en) begin
            if (pri_ok)       state_d = ST_AUTO_PRI;
            else if (sec_use) state_d = ST_AUTO_SEC;
            else              state_d = ST_AUTO_PARK;
        end else begin
            state_d = man_sec ? ST_MAN_SEC : ST_MAN_PRI;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_AUTO_PARK;
            sel_d_q  <= 1'b1;
            los_q    <= 1'b1;
            handed_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            sel_d_q  <= sel_sec;
            los_q    <= ~pri_ok & ~sec_use;
            handed_q <= handed_q | (on_auto_pri & ~keep_sec);
        end
    end

    always_comb begin
        sel_sec     = 1'b1;
        on_auto_pri = 1'b0;
        unique case (state_q)
            ST_AUTO_PRI: begin
                sel_sec     = 1'b0;
                on_auto_pri = 1'b1;
            end
            ST_AUTO_SEC:  sel_sec = 1'b1;
            ST_AUTO_PARK: sel_sec = 1'b1;
            ST_MAN_PRI:   sel_sec = 1'b0;
            ST_MAN_SEC:   sel_sec = 1'b1;
            default:      sel_sec = 1'b1;
        endcase
    end

    assign switch_req = sel_sec ^ sel_d_q;
    assign los        = los_q;

    // R7: qualified primary in automatic mode selects primary next cycle
    p_auto_revert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && pri_ok) |=> !sel_sec);

    // R6: primary lost in automatic mode moves to secondary next cycle
    p_auto_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !pri_ok) |=> sel_sec);

    // R9: every change of the select produces the request pulse
    p_switch_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sec != $past(sel_sec)) |-> switch_req);

    // R10: once shut, the secondary path stays shut unless keep_sec is set
    p_path_stays_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_path_en) |=> (!sec_path_en || keep_sec));

endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import refclk_sel_pkg::*;
#(
    parameter int STABLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] pin_lvl,
    input  logic       keep_sec,
    input  logic       pri_avail,
    input  logic       sec_avail,
    output logic       sel_sec,
    output logic       switch_req,
    output logic       los,
    output logic       out_dis,
    output logic       sec_path_en
);

    localparam int NUM_REF = 2;

    logic [NUM_REF-1:0] raw_flags;
    logic [NUM_REF-1:0] qual_flags;
    logic               auto_en;
    logic               man_sec;

    assign raw_flags = {sec_avail, pri_avail};

    for (genvar i = 0; i < NUM_REF; i++) begin : g_qual
        refclk_qualify #(.STABLE_CYC(STABLE_CYC)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_flags[i]),
            .q_o   (qual_flags[i])
        );
    end

    refclk_mode_dec u_dec (
        .cfg_mode (cfg_mode),
        .pin_lvl  (pin_lvl),
        .auto_en  (auto_en),
        .man_sec  (man_sec)
    );

    refclk_sel_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en     (auto_en),
        .man_sec     (man_sec),
        .pri_ok      (qual_flags[0]),
        .sec_ok      (qual_flags[1]),
        .keep_sec    (keep_sec),
        .sel_sec     (sel_sec),
        .switch_req  (switch_req),
        .los         (los),
        .sec_path_en (sec_path_en)
    );

    assign out_dis = los;

    // R4: forced primary
    p_forced_pri_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_F_PRI) |=> !sel_sec);

    // R4: forced secondary
    p_forced_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_F_SEC) |=> sel_sec);

    // R3: pin low with pin-controlled mode picks primary
    p_pin_low_pri_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_PIN && pin_lvl == 2'b00) |=> !sel_sec);

    // R11: keep_sec holds the secondary path on
    p_keep_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
        keep_sec |-> sec_path_en);

endmodule

// File: tb/refclk_selector_tb.sv
module refclk_selector_tb;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] pin_lvl = 2'b00;
    logic       keep_sec = 1'b1;
    logic       pri_avail = 1'b0;
    logic       sec_avail = 1'b0;
    logic       sel_sec, switch_req, los, out_dis, sec_path_en;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    refclk_selector #(.STABLE_CYC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .pin_lvl(pin_lvl),
        .keep_sec(keep_sec), .pri_avail(pri_avail), .sec_avail(sec_avail),
        .sel_sec(sel_sec), .switch_req(switch_req), .los(los),
        .out_dis(out_dis), .sec_path_en(sec_path_en)
    );

    // reference model built from the requirements
    int m_cnt [2];
    bit m_q [2];
    bit m_sel = 1, m_sel_d = 1, m_los = 1, m_hand = 0, m_auto_st = 1;
    bit t_raw [2];
    bit t_en, t_use, t_auto, t_ms, n_sel, n_los, n_hand;

    function automatic bit [1:0] decode(input bit [1:0] md, input bit [1:0] pl);
        case (md)
            2'b00: return 2'b10;
            2'b01: return (pl == 2'b00) ? 2'b00 : (pl == 2'b01) ? 2'b01 : 2'b10;
            2'b10: return 2'b00;
            default: return 2'b01;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt[0] = 0; m_cnt[1] = 0; m_q[0] = 0; m_q[1] = 0;
            m_sel = 1; m_sel_d = 1; m_los = 1; m_hand = 0; m_auto_st = 1;
        end else begin
            t_raw[0] = pri_avail; t_raw[1] = sec_avail;
            t_en  = keep_sec | !m_hand;
            t_use = m_q[1] & t_en;
            {t_auto, t_ms} = decode(cfg_mode, pin_lvl);
            n_sel  = t_auto ? !m_q[0] : t_ms;
            n_los  = !m_q[0] & !t_use;
            n_hand = m_hand | (m_auto_st & !m_sel & !keep_sec);
            m_sel_d = m_sel; m_sel = n_sel; m_auto_st = t_auto;
            m_los = n_los; m_hand = n_hand;
            for (int i = 0; i < 2; i++) begin
                if (t_raw[i] == m_q[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == N - 1) begin m_q[i] = t_raw[i]; m_cnt[i] = 0; end
                else m_cnt[i]++;
            end
        end
    end

    task automatic chk(input bit act, input bit exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_model();
        chk(sel_sec, m_sel, "R2 R3 R4 R6 R7 sel_sec vs model");
        chk(switch_req, m_sel ^ m_sel_d, "R9 switch_req vs model");
        chk(los, m_los, "R8 los vs model");
        chk(out_dis, m_los, "R8 out_dis vs model");
        chk(sec_path_en, keep_sec | !m_hand, "R10 R11 sec_path_en vs model");
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk_model();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(sel_sec, 1'b1, "R1 sel_sec");
        chk(los, 1'b1, "R1 los");
        chk(out_dis, 1'b1, "R1 out_dis");
        chk(sec_path_en, 1'b1, "R1 sec_path_en");
        chk(switch_req, 1'b0, "R1 switch_req");

        // R5 short primary pulse is ignored
        pri_avail = 1'b1; step(N - 1);
        pri_avail = 1'b0; step(4);
        chk(sel_sec, 1'b1, "R5 short pulse sel_sec");
        chk(los, 1'b1, "R5 short pulse los");

        // R7 primary qualified -> primary selected after N+1 edges
        pri_avail = 1'b1; step(N);
        chk(sel_sec, 1'b1, "R7 before commit");
        step(1);
        chk(sel_sec, 1'b0, "R7 reverted to primary");
        chk(switch_req, 1'b1, "R9 pulse on revert");
        step(1);
        chk(switch_req, 1'b0, "R9 pulse width one");
        chk(los, 1'b0, "R8 los clears");

        // R2 pin ignored in mode 00
        pin_lvl = 2'b01; step(3);
        chk(sel_sec, 1'b0, "R2 pin ignored");

        // R6 primary lost, secondary available
        sec_avail = 1'b1; step(N + 1);
        pri_avail = 1'b0; step(N + 1);
        chk(sel_sec, 1'b1, "R6 fallback");
        chk(los, 1'b0, "R6 los low on backup");

        // R8 both lost: parked on secondary, los and out_dis high
        sec_avail = 1'b0; step(N + 1);
        chk(sel_sec, 1'b1, "R8 parked");
        chk(los, 1'b1, "R8 los");
        chk(out_dis, 1'b1, "R8 out_dis");

        // R3 pin decode in mode 01
        cfg_mode = 2'b01; pin_lvl = 2'b00; step(2);
        chk(sel_sec, 1'b0, "R3 pin low manual primary");
        pin_lvl = 2'b01; step(2);
        chk(sel_sec, 1'b1, "R3 pin mid manual secondary");
        pri_avail = 1'b1; pin_lvl = 2'b11; step(N + 2);
        chk(sel_sec, 1'b0, "R3 pin code 11 is automatic");

        // R4 forced modes
        cfg_mode = 2'b11; pin_lvl = 2'b00; step(2);
        chk(sel_sec, 1'b1, "R4 forced secondary");
        cfg_mode = 2'b10; pin_lvl = 2'b01; step(2);
        chk(sel_sec, 1'b0, "R4 forced primary");

        // R10 one-time handover with keep_sec = 0
        cfg_mode = 2'b00; pri_avail = 1'b0; sec_avail = 1'b0; keep_sec = 1'b0;
        do_reset();
        sec_avail = 1'b1; step(N + 2);
        chk(sel_sec, 1'b1, "R10 started on secondary");
        chk(sec_path_en, 1'b1, "R10 path on before handover");
        pri_avail = 1'b1; step(N + 1);
        chk(sel_sec, 1'b0, "R10 handed to primary");
        step(1);
        chk(sec_path_en, 1'b0, "R10 path shut after handover");
        pri_avail = 1'b0; step(N + 2);
        chk(sel_sec, 1'b1, "R10 parked with secondary shut");
        chk(los, 1'b1, "R10 secondary counts as unavailable");
        keep_sec = 1'b1; step(1);
        chk(sec_path_en, 1'b1, "R11 keep_sec reopens path");
        step(1);
        chk(los, 1'b0, "R11 secondary usable again");

        // constrained random phase
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            chk_model();
            if ($urandom_range(0, 9) == 0) pri_avail = ~pri_avail;
            if ($urandom_range(0, 9) == 0) sec_avail = ~sec_avail;
            if ($urandom_range(0, 59) == 0) cfg_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 59) == 0) pin_lvl = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 199) == 0) keep_sec = ~keep_sec;
            if ($urandom_range(0, 1499) == 0) begin
                do_reset();
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule